// File: doc/BRIEF.md
# Page Permission Fault Checker

This block decides, for one translated memory access at a time, whether the access may proceed. It takes the leaf page-table entry returned by the page walker, or a flag saying the walker found no mapping. It also takes the kind of access (instruction fetch, load or store), the privilege mode of the requester, and two supervisor status controls. The first control, make-executable-readable, lets loads read pages that are marked executable. The second, supervisor-user-access, lets supervisor code touch pages that user code may access.

Each accepted request produces exactly one response one clock later. The response is either an allow or a page fault. A fault carries a cause code chosen by the access kind and the faulting virtual address as its trap value. The surrounding trap logic consumes the fault. Nothing in this block vectors traps or updates status registers.

Top module: `page_perm_check`

## Requirements
- R1: When `pte_hit` is 0 the access faults, whatever the entry bits and controls are.
- R2: An entry with its valid bit (bit 0) clear faults.
- R3: The entry bit that must be set depends on the access kind (`req_kind` 0 = fetch, 1 = load, 2 or 3 = store). A fetch needs execute (bit 3), a load needs read (bit 1) and a store needs write (bit 2). If the needed bit is clear, the access faults.
- R4: With `mxr` = 0, a load from a page with read clear faults even if execute is set.
- R5: With `mxr` = 1, a load succeeds from a page with read or execute set. Fetches and stores are not affected by `mxr`.
- R6: With `req_sup` = 1 and `sum` = 0, any access to a page with the user bit (bit 4) set faults. With `sum` = 1, the user bit does not block a supervisor access.
- R7: With `req_sup` = 0, an access to a page with the user bit clear faults.
- R8: The fault cause is 12 for a fetch, 13 for a load and 15 for a store. On a fault, `rsp_tval` equals the request's virtual address. On an allow, `rsp_tval` is 0.
- R9: `rsp_valid`, `rsp_allow` and `rsp_fault` are registered, with one cycle of latency after a request. `rsp_allow` and `rsp_fault` are never both 1, and exactly one of them is 1 when `rsp_valid` is 1. With no request, all three are 0 on the next cycle.
- R10: A synchronous active-high `rst` clears `rsp_valid`, `rsp_allow`, `rsp_fault`, `rsp_cause` and `rsp_tval` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | VA_W | Virtual address of the access |
| req_kind | input | 2 | 0 fetch, 1 load, 2 or 3 store |
| req_sup | input | 1 | 1 supervisor mode, 0 user mode |
| mxr | input | 1 | Loads may read execute-only pages |
| sum | input | 1 | Supervisor may access user pages |
| pte_hit | input | 1 | Walker returned a leaf entry |
| pte | input | PTE_W | Leaf entry flag bits (V0 R1 W2 X3 U4) |
| rsp_valid | output | 1 | Response present |
| rsp_allow | output | 1 | Access permitted |
| rsp_fault | output | 1 | Page fault raised |
| rsp_cause | output | CAUSE_W | Fault cause code, 0 when allowed |
| rsp_tval | output | VA_W | Faulting address, 0 when allowed |

## Verification
The hardest cases to reach are those where several denial rules overlap, or where one control bit alone changes the outcome. Examples are an execute-only page read with each setting of `mxr`, and a user page accessed from supervisor mode with each setting of `sum`. Each of these is a directed pair of requests. The two requests differ in exactly one input, so a fault in one and an allow in the other can be traced to that input alone. Back-to-back requests of different kinds check that the cause and trap value follow each request.

// File: rtl/pgchk_pkg.sv
package pgchk_pkg;
  // Entry flag positions
  localparam int unsigned FLG_V = 0;
  localparam int unsigned FLG_R = 1;
  localparam int unsigned FLG_W = 2;
  localparam int unsigned FLG_X = 3;
  localparam int unsigned FLG_U = 4;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_STALT = 2'd3
  } acc_kind_e;

  localparam logic [3:0] CAUSE_IPF = 4'd12;
  localparam logic [3:0] CAUSE_LPF = 4'd13;
  localparam logic [3:0] CAUSE_SPF = 4'd15;
endpackage

// File: rtl/pgchk_perm.sv
// Required-permission check: execute for fetch, read (or execute under mxr) for load, write for store.
module pgchk_perm
  import pgchk_pkg::*;
(
  input  logic [1:0] kind,
  input  logic       mxr,
  input  logic       f_r,
  input  logic       f_w,
  input  logic       f_x,
  output logic       ok
);
  always_comb begin
    unique case (acc_kind_e'(kind))
      ACC_FETCH: ok = f_x;
      ACC_LOAD:  ok = f_r | (mxr & f_x);
      default:   ok = f_w;
    endcase
  end
endmodule

// File: rtl/pgchk_priv.sv
// Privilege check against the user flag.
module pgchk_priv (
  input  logic sup,
  input  logic sum,
  input  logic f_u,
  output logic ok
);
  always_comb begin
    if (sup) ok = !f_u || sum;
    else     ok = f_u;
  end
endmodule

// File: rtl/pgchk_cause.sv
// Maps access kind to page-fault cause code.
module pgchk_cause
  import pgchk_pkg::*;
#(
  parameter int unsigned CAUSE_W = 4
) (
  input  logic [1:0]         kind,
  output logic [CAUSE_W-1:0] cause
);
  always_comb begin
    unique case (acc_kind_e'(kind))
      ACC_FETCH: cause = CAUSE_W'(CAUSE_IPF);
      ACC_LOAD:  cause = CAUSE_W'(CAUSE_LPF);
      default:   cause = CAUSE_W'(CAUSE_SPF);
    endcase
  end
endmodule

// File: rtl/page_perm_check.sv
module page_perm_check
  import pgchk_pkg::*;
#(
  parameter int unsigned VA_W    = 32,
  parameter int unsigned PTE_W   = 10,
  parameter int unsigned CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [1:0]         req_kind,
  input  logic               req_sup,
  input  logic               mxr,
  input  logic               sum,
  input  logic               pte_hit,
  input  logic [PTE_W-1:0]   pte,
  output logic               rsp_valid,
  output logic               rsp_allow,
  output logic               rsp_fault,
  output logic [CAUSE_W-1:0] rsp_cause,
  output logic [VA_W-1:0]    rsp_tval
);
  localparam int unsigned MIN_PTE_W = FLG_U + 1;

  if (PTE_W < MIN_PTE_W) begin : g_bad_width
    initial $error("PTE_W too small for flag set");
  end

  logic perm_ok, priv_ok, grant;
  logic [CAUSE_W-1:0] cause_c;

  pgchk_perm u_perm (
    .kind (req_kind),
    .mxr  (mxr),
    .f_r  (pte[FLG_R]),
    .f_w  (pte[FLG_W]),
    .f_x  (pte[FLG_X]),
    .ok   (perm_ok)
  );

  pgchk_priv u_priv (
    .sup (req_sup),
    .sum (sum),
    .f_u (pte[FLG_U]),
    .ok  (priv_ok)
  );

  pgchk_cause #(.CAUSE_W(CAUSE_W)) u_cause (
    .kind  (req_kind),
    .cause (cause_c)
  );

  assign grant = pte_hit && pte[FLG_V] && perm_ok && priv_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= '0;
      rsp_tval  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_allow <= req_valid && grant;
      rsp_fault <= req_valid && !grant;
      rsp_cause <= (req_valid && !grant) ? cause_c : '0;
      rsp_tval  <= (req_valid && !grant) ? req_vaddr : '0;
    end
  end

  // History qualifier so that $past never reaches into reset
  logic hist_ok;
  always_ff @(posedge clk) begin
    if (rst) hist_ok <= 1'b0;
    else     hist_ok <= 1'b1;
  end

  // R9
  exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(rsp_allow && rsp_fault));

  // R9
  one_answer_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_allow, rsp_fault}) == 1);

  // R9
  latency_chk: assert property (@(posedge clk) disable iff (rst || !hist_ok)
    rsp_valid == $past(req_valid));

  // R1
  nomap_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !pte_hit) |=> rsp_fault);

  // R2
  invalid_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && pte_hit && !pte[FLG_V]) |=> rsp_fault);

  // R8
  tval_chk: assert property (@(posedge clk) disable iff (rst || !hist_ok)
    rsp_fault |-> rsp_tval == $past(req_vaddr));

  // R8
  fetch_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'd0) |=> (!rsp_fault || rsp_cause == CAUSE_W'(12)));
endmodule

// File: tb/sim_page_perm_check.sv
module sim_page_perm_check;
  localparam int VA_W = 32;
  localparam int PTE_W = 10;
  localparam int CAUSE_W = 4;

  logic clk = 1'b0;
  logic rst;
  logic req_valid;
  logic [VA_W-1:0] req_vaddr;
  logic [1:0] req_kind;
  logic req_sup, mxr, sum, pte_hit;
  logic [PTE_W-1:0] pte;
  logic rsp_valid, rsp_allow, rsp_fault;
  logic [CAUSE_W-1:0] rsp_cause;
  logic [VA_W-1:0] rsp_tval;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  page_perm_check #(.VA_W(VA_W), .PTE_W(PTE_W), .CAUSE_W(CAUSE_W)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_sup(req_sup), .mxr(mxr), .sum(sum),
    .pte_hit(pte_hit), .pte(pte), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
    .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .rsp_tval(rsp_tval)
  );

  // flag encodings: V=1, R=2, W=4, X=8, U=16
  localparam logic [PTE_W-1:0] V = 10'h01, R = 10'h02, W = 10'h04, X = 10'h08, U = 10'h10;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issue one request, sample the registered response one cycle later.
  task automatic access(input string req, input logic [1:0] kind, input logic sup,
                        input logic m, input logic s, input logic hit,
                        input logic [PTE_W-1:0] flags, input logic [VA_W-1:0] va,
                        input logic exp_allow);
    logic [CAUSE_W-1:0] ec;
    ec = (kind == 2'd0) ? 4'd12 : (kind == 2'd1) ? 4'd13 : 4'd15;
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_sup = sup; mxr = m; sum = s;
    pte_hit = hit; pte = flags; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " valid"}, 64'(rsp_valid), 64'd1);
    chk({req, " allow"}, 64'(rsp_allow), 64'(exp_allow));
    chk({req, " fault"}, 64'(rsp_fault), 64'(!exp_allow));
    chk({req, " cause R8"}, 64'(rsp_cause), exp_allow ? 64'd0 : 64'(ec));
    chk({req, " tval R8"}, 64'(rsp_tval), exp_allow ? 64'd0 : 64'(va));
  endtask

  task automatic t_reset;
    chk("R10 valid", 64'(rsp_valid), 0);
    chk("R10 allow", 64'(rsp_allow), 0);
    chk("R10 fault", 64'(rsp_fault), 0);
    chk("R10 cause", 64'(rsp_cause), 0);
    chk("R10 tval", 64'(rsp_tval), 0);
  endtask

  task automatic t_nomap;
    access("R1 fetch", 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, V|R|W|X, 32'h1000_0004, 1'b0);
    access("R1 load",  2'd1, 1'b0, 1'b1, 1'b1, 1'b0, V|R|W|X|U, 32'h2000_0008, 1'b0);
    access("R1 store", 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, V|R|W|X, 32'h3000_000c, 1'b0);
  endtask

  task automatic t_invalid;
    access("R2 load", 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, R|W|X, 32'h0000_4444, 1'b0);
    access("R2 ctl",  2'd1, 1'b1, 1'b0, 1'b0, 1'b1, V|R|W|X, 32'h0000_4444, 1'b1);
  endtask

  task automatic t_perm;
    access("R3 fetch ok",   2'd0, 1'b1, 1'b0, 1'b0, 1'b1, V|X, 32'h10, 1'b1);
    access("R3 fetch nox",  2'd0, 1'b1, 1'b0, 1'b0, 1'b1, V|R|W, 32'h14, 1'b0);
    access("R3 load ok",    2'd1, 1'b1, 1'b0, 1'b0, 1'b1, V|R, 32'h18, 1'b1);
    access("R3 load nor",   2'd1, 1'b1, 1'b0, 1'b0, 1'b1, V|W, 32'h1c, 1'b0);
    access("R3 store ok",   2'd2, 1'b1, 1'b0, 1'b0, 1'b1, V|R|W, 32'h20, 1'b1);
    access("R3 store now",  2'd2, 1'b1, 1'b0, 1'b0, 1'b1, V|R|X, 32'h24, 1'b0);
    access("R3 store alt",  2'd3, 1'b1, 1'b0, 1'b0, 1'b1, V|R, 32'h28, 1'b0);
  endtask

  task automatic t_mxr;
    access("R4 exec-only load", 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, V|X, 32'hABCD_0000, 1'b0);
    access("R5 exec-only load", 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, V|X, 32'hABCD_0000, 1'b1);
    access("R5 store unaffected", 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, V|X, 32'hABCD_0010, 1'b0);
    access("R5 fetch unaffected", 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, V|R, 32'hABCD_0020, 1'b0);
  endtask

  task automatic t_sum;
    access("R6 sum0 load", 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, V|R|U, 32'h5000_0000, 1'b0);
    access("R6 sum1 load", 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, V|R|U, 32'h5000_0000, 1'b1);
    access("R6 sum0 fetch", 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, V|X|U, 32'h5000_0100, 1'b0);
  endtask

  task automatic t_user;
    access("R7 user nou", 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, V|W, 32'h6000_0000, 1'b0);
    access("R7 user u",   2'd2, 1'b0, 1'b0, 1'b0, 1'b1, V|W|U, 32'h6000_0000, 1'b1);
  endtask

  task automatic t_idle;
    @(negedge clk);
    pte_hit = 1'b0;
    @(negedge clk);
    chk("R9 idle valid", 64'(rsp_valid), 0);
    chk("R9 idle fault", 64'(rsp_fault), 0);
    chk("R9 idle allow", 64'(rsp_allow), 0);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_kind = '0;
    req_sup = 1'b0; mxr = 1'b0; sum = 1'b0; pte_hit = 1'b0; pte = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_nomap();
    t_invalid();
    t_perm();
    t_mxr();
    t_sum();
    t_user();
    t_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule